// File: doc/BRIEF.md
# Programmable Johnson-Ring Frequency Divider

This block divides an input clock by any integer ratio from 2 to 10 using a five-stage twisted-ring shift register. A four-bit ratio field picks the feedback internally. For even ratios the inverted output of the last stage in the loop feeds stage one. For odd ratios the NAND of the last two stages in the loop feeds stage one, so the loop drops one state and the cycle shrinks by one. The divided clock is taken from that feedback net, and each of the five stage values is also brought out.

A high clear empties the ring and a high preset copies a five-bit pattern into it. Both act at once, without a clock edge, and clear wins when both are high. Preset can leave the ring in a pattern that is not part of any counting sequence. Anti-lock logic detects such a pattern and zeroes the ring on the next edge, so counting always resumes. Ratio value 0 turns the block into a plain shift register fed from a serial data pin, which lets the user build feedback outside the block. The chip-level active-low reset is applied at once and released in step with the clock.

Top module: `johnson_divn`

## Requirements
- R1: While rst_n is low, stage_q is 0. After rst_n rises, the ring starts moving only after a two-edge release delay.
- R2: Outside clear and preset, on each rising clock edge stage k+1 takes the old value of stage k. Stage 1 (stage_q bit 0) takes the feedback value.
- R3: A high clear drives stage_q to 0 without a clock edge. stage_q stays 0 through any clock edges while clear is held.
- R4: A high preset (with clear low) loads jam into the ring without a clock edge, with jam bit 0 going to stage 1. The pattern is held through clock edges while preset stays high.
- R5: When clear and preset are both high, stage_q is 0.
- R6: For an even ratio N, stage 1 takes the inverse of stage N/2. div_out is high for N/2 of every N clocks. Starting from zero with ratio 10, stages fill with ones from stage 1 upward, then empty in the same order.
- R7: For an odd ratio N, stage 1 takes the NAND of stages (N-1)/2 and (N+1)/2. div_out repeats every N clocks and is high for (N+1)/2 of them.
- R8: From any of the 32 preset patterns and for every ratio from 2 to 10, div_out is periodic with period N within 2N clocks. A pattern outside the counting sequence of the selected loop is replaced by all zeros on the next edge.
- R9: Ratio 0 is raw mode: stage 1 takes din on each edge, no anti-lock applies, and div_out equals stage 5.
- R10: Ratio values 1 and 11 to 15 behave exactly like ratio 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock, rising edge active |
| rst_n | input | 1 | Chip reset, active low, asynchronous assert, synchronous release |
| clear | input | 1 | Asynchronous ring clear, active high |
| preset | input | 1 | Asynchronous parallel load of jam, active high |
| jam | input | 5 | Preset pattern, bit 0 goes to stage 1 |
| din | input | 1 | Serial data into stage 1 in raw mode |
| ratio | input | 4 | Division ratio 2..10; 0 selects raw mode; other values act as 10 |
| stage_q | output | 5 | Stage values, bit 0 is stage 1 |
| div_out | output | 1 | Divided clock (feedback net), or stage 5 in raw mode |

## Verification
The hardest condition to reach is a ring pattern that lies off the counting sequence, because normal counting never produces one. The stimulus reaches it with a short preset pulse between clock edges. It sweeps all 32 jam patterns under every ratio from 2 to 10, lets 2N edges pass, and then measures the interval between two rising edges of div_out and the number of high cycles in it. Odd ratios are covered by the same sweep, which also starts from patterns the shortened loop skips.

// File: rtl/jd_pkg.sv
package jd_pkg;
  localparam int unsigned JD_STAGES = 5;
  localparam int unsigned JD_SEL_W  = 4;
  localparam int unsigned JD_LEN_W  = $clog2(JD_STAGES + 1);

  function automatic int unsigned jd_max_ratio(int unsigned stages);
    return 2 * stages;
  endfunction
endpackage

// File: rtl/jd_reset_sync.sv
module jd_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;
endmodule

// File: rtl/jd_ratio_decode.sv
module jd_ratio_decode #(
  parameter int unsigned STAGES = jd_pkg::JD_STAGES,
  parameter int unsigned SEL_W  = jd_pkg::JD_SEL_W,
  localparam int unsigned LEN_W = $clog2(STAGES + 1)
) (
  input  logic [SEL_W-1:0] sel,
  output logic             raw,
  output logic             odd,
  output logic [LEN_W-1:0] loop_len
);
  localparam logic [SEL_W-1:0] MAX_N = SEL_W'(jd_pkg::jd_max_ratio(STAGES));
  localparam logic [SEL_W-1:0] MIN_N = SEL_W'(2);

  logic [SEL_W-1:0] n_eff;
  logic [SEL_W:0]   n_plus;

  always_comb begin
    raw    = (sel == '0);
    n_eff  = ((sel >= MIN_N) && (sel <= MAX_N)) ? sel : MAX_N;
    odd    = n_eff[0];
    n_plus = {1'b0, n_eff} + {{SEL_W{1'b0}}, 1'b1};
    loop_len = LEN_W'(n_plus >> 1);
  end
endmodule

// File: rtl/jd_feedback.sv
module jd_feedback #(
  parameter int unsigned STAGES = jd_pkg::JD_STAGES,
  localparam int unsigned LEN_W = $clog2(STAGES + 1)
) (
  input  logic [STAGES-1:0] q,
  input  logic              raw,
  input  logic              odd,
  input  logic [LEN_W-1:0]  loop_len,
  output logic              fb,
  output logic              legal
);
  logic [STAGES-2:0] edge_in_loop;
  logic [LEN_W-1:0]  idx_hi;
  logic [LEN_W-1:0]  idx_lo;

  // one flag per adjacent stage pair inside the active loop
  for (genvar i = 0; i < STAGES - 1; i++) begin : g_pair
    assign edge_in_loop[i] = (q[i] ^ q[i+1]) & (LEN_W'(i + 1) < loop_len);
  end

  always_comb begin
    idx_hi = (loop_len == '0) ? '0 : loop_len - LEN_W'(1);
    idx_lo = (loop_len < LEN_W'(2)) ? '0 : loop_len - LEN_W'(2);
    if (odd) fb = ~(q[idx_lo] & q[idx_hi]);
    else     fb = ~q[idx_hi];
    legal = raw ? 1'b1 : ($countones(edge_in_loop) <= 1);
  end
endmodule

// File: rtl/jd_stage_ring.sv
module jd_stage_ring #(
  parameter int unsigned STAGES = jd_pkg::JD_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              pre,
  input  logic [STAGES-1:0] jam,
  input  logic [STAGES-1:0] d,
  output logic [STAGES-1:0] q,
  output logic              touched
);
  logic [STAGES-1:0] q_r;
  logic              touched_r;

  // asynchronous clear beats asynchronous load; otherwise the ring takes d
  always_ff @(posedge clk or negedge rst_n or posedge clr or posedge pre) begin
    if (!rst_n) begin
      q_r       <= '0;
      touched_r <= 1'b0;
    end else if (clr) begin
      q_r       <= '0;
      touched_r <= 1'b1;
    end else if (pre) begin
      q_r       <= jam;
      touched_r <= 1'b1;
    end else begin
      q_r       <= d;
      touched_r <= 1'b0;
    end
  end

  assign q       = q_r;
  assign touched = touched_r;

  p_clear_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> (q_r == '0));

  p_clear_over_preset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && pre) |-> (q_r == '0));

  p_preset_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pre && !clr) |-> (q_r == jam));
endmodule

// File: rtl/johnson_divn.sv
module johnson_divn #(
  parameter int unsigned STAGES = jd_pkg::JD_STAGES,
  parameter int unsigned SEL_W  = jd_pkg::JD_SEL_W,
  localparam int unsigned LEN_W = $clog2(STAGES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              preset,
  input  logic [STAGES-1:0] jam,
  input  logic              din,
  input  logic [SEL_W-1:0]  ratio,
  output logic [STAGES-1:0] stage_q,
  output logic              div_out
);
  logic              rst_sync_n;
  logic              raw;
  logic              odd;
  logic [LEN_W-1:0]  loop_len;
  logic              fb;
  logic              legal;
  logic              touched;
  logic [STAGES-1:0] q;
  logic [STAGES-1:0] q_nxt;
  logic              advance_en;

  jd_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  jd_ratio_decode #(.STAGES(STAGES), .SEL_W(SEL_W)) u_dec (
    .sel      (ratio),
    .raw      (raw),
    .odd      (odd),
    .loop_len (loop_len)
  );

  jd_feedback #(.STAGES(STAGES)) u_fb (
    .q        (q),
    .raw      (raw),
    .odd      (odd),
    .loop_len (loop_len),
    .fb       (fb),
    .legal    (legal)
  );

  // next-state: raw shift, anti-lock zeroing, or normal ring step
  always_comb begin
    advance_en = 1'b1;
    q_nxt      = q;
    if (advance_en) begin
      if (raw)         q_nxt = {q[STAGES-2:0], din};
      else if (!legal) q_nxt = '0;
      else             q_nxt = {q[STAGES-2:0], fb};
    end
  end

  jd_stage_ring #(.STAGES(STAGES)) u_ring (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr     (clear),
    .pre     (preset),
    .jam     (jam),
    .d       (q_nxt),
    .q       (q),
    .touched (touched)
  );

  assign stage_q = q;
  assign div_out = raw ? q[STAGES-1] : fb;

  p_ring_step_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!clear && !preset && !raw && legal) |=>
      (touched || clear || preset ||
       ((q[STAGES-1:1] == $past(q[STAGES-2:0])) && (q[0] == $past(fb)))));

  p_raw_shift_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!clear && !preset && raw) |=>
      (touched || clear || preset ||
       (q == {$past(q[STAGES-2:0]), $past(din)})));

  p_antilock_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!clear && !preset && !raw && !legal) |=>
      (touched || clear || preset || (q == '0)));

  p_reset_hold_r1: assert property (@(posedge clk)
    (!rst_sync_n && !clear && !preset) |-> (q == '0));
endmodule

// File: tb/johnson_divn_test.sv
module johnson_divn_test;
  logic       clk;
  logic       rst_n;
  logic       clear;
  logic       preset;
  logic [4:0] jam;
  logic       din;
  logic [3:0] ratio;
  logic [4:0] stage_q;
  logic       div_out;

  int total;
  int bad;
  bit done;

  johnson_divn uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clear),
    .preset  (preset),
    .jam     (jam),
    .din     (din),
    .ratio   (ratio),
    .stage_q (stage_q),
    .div_out (div_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic pulse_clear();
    clear = 1'b1; #1; clear = 1'b0; #1;
  endtask

  task automatic pulse_preset(input logic [4:0] p);
    jam = p; #1; preset = 1'b1; #1; preset = 1'b0; #1;
  endtask

  // expected ring contents m steps after zero with ratio 10
  function automatic logic [4:0] dec_pattern(input int m);
    int k = m % 10;
    if (k <= 5) return 5'((1 << k) - 1);
    return 5'h1F & ~5'((1 << (k - 5)) - 1);
  endfunction

  task automatic measure(input int n, input string per_tag, input string duty_tag);
    int a = -1;
    int b = -1;
    int highs = 0;
    logic prev = div_out;
    for (int k = 0; k < 3 * n; k++) begin
      tick();
      if (!prev && div_out) begin
        if (a < 0) a = k;
        else if (b < 0) b = k;
      end
      if (a >= 0 && b < 0 && div_out) highs++;
      prev = div_out;
    end
    chk((a >= 0) && (b >= 0) && (b - a == n), per_tag, b - a, n);
    chk(highs == (n + 1) / 2, duty_tag, highs, (n + 1) / 2);
  endtask

  initial begin
    #150000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [4:0] exp_q;
    total = 0; bad = 0; done = 1'b0;
    rst_n = 1'b0; clear = 1'b0; preset = 1'b0;
    jam = '0; din = 1'b0; ratio = 4'd10;
    #1;
    chk(stage_q == 5'd0, "R1 reset state", stage_q, 0);
    tick(); tick();
    chk(stage_q == 5'd0, "R1 held in reset", stage_q, 0);
    rst_n = 1'b1;
    tick();
    chk(stage_q == 5'd0, "R1 release delay", stage_q, 0);
    tick(); tick();

    // R6 / R2: decade sequence from zero
    pulse_clear();
    for (int m = 1; m <= 20; m++) begin
      tick();
      chk(stage_q == dec_pattern(m), "R2 R6 decade step", stage_q, dec_pattern(m));
    end

    // R4: async preset and hold
    tick();
    jam = 5'b10110; #1;
    preset = 1'b1; #1;
    chk(stage_q == 5'b10110, "R4 async load", stage_q, 5'b10110);
    tick(); tick();
    chk(stage_q == 5'b10110, "R4 held under clock", stage_q, 5'b10110);
    preset = 1'b0; #1;

    // R3: async clear and hold
    clear = 1'b1; #1;
    chk(stage_q == 5'd0, "R3 async clear", stage_q, 0);
    tick(); tick();
    chk(stage_q == 5'd0, "R3 held under clock", stage_q, 0);

    // R5: clear beats preset
    jam = 5'h1F; #1;
    preset = 1'b1; #1;
    chk(stage_q == 5'd0, "R5 clear priority", stage_q, 0);
    tick();
    chk(stage_q == 5'd0, "R5 clear priority clocked", stage_q, 0);
    preset = 1'b0; #1; clear = 1'b0; #1;

    // R9: raw shift from din
    ratio = 4'd0;
    pulse_clear();
    exp_q = '0;
    for (int m = 0; m < 16; m++) begin
      din = 1'((m * 7 + m / 3) % 2);
      tick();
      exp_q = {exp_q[3:0], din};
      chk(stage_q == exp_q, "R9 raw shift", stage_q, exp_q);
      chk(div_out == exp_q[4], "R9 raw div_out", div_out, exp_q[4]);
    end

    // R10: out-of-range ratio values act as 10
    ratio = 4'd13;
    pulse_clear();
    measure(10, "R10 ratio 13 period", "R10 ratio 13 duty");
    ratio = 4'd1;
    pulse_clear();
    measure(10, "R10 ratio 1 period", "R10 ratio 1 duty");

    // R8 / R6 / R7: every preset pattern under every ratio
    for (int r = 2; r <= 10; r++) begin
      for (int p = 0; p < 32; p++) begin
        ratio = 4'(r);
        pulse_preset(5'(p));
        for (int s = 0; s < 2 * r; s++) tick();
        measure(r, "R8 settled period", (r % 2 == 1) ? "R7 odd duty" : "R6 even duty");
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule